// File: doc/BRIEF.md
# Four-Buffer Circular Trace Writer

The block takes a stream of trace record words and stores them in memory across a ring of four buffers. Every buffer has its own programmed base address, and all four share one programmed size counted in words. Words go into buffer 0 first, then 1, 2 and 3. As long as tracing stays switched on, writing then returns to buffer 0 and continues around the ring. Each word goes out through a simple memory port that issues one write request at a time and waits for an acknowledge.

When the last word of a buffer is acknowledged, the block emits a one-cycle completion pulse that carries the 2-bit index of that buffer. It also sets a per-buffer sticky flag, which software clears by writing a one to the matching bit. When tracing is switched off, any write already in flight is allowed to finish. The block then reports which buffer it was in and how many words that buffer holds, and it stops. The next enable starts again at the beginning of buffer 0.

The size input is a word count, and the default width reaches 2^20 words, which is a 4 MiB buffer of 32-bit words. The byte address of each word is the buffer base plus four times the word's offset within the buffer.

Top module: `trace_ring_writer`

## Requirements
- R1: After reset, memReq, inReady, doneStrobe and stopStrobe are low and doneSticky is 0000.
- R2: inReady is high only while traceEnable is high and no memory write is waiting for its acknowledge. While traceEnable is low, inValid causes no memory request.
- R3: Once memReq rises, it stays high with memAddr and memData unchanged until the cycle in which memAck is high. After that acknowledge, memReq is low in the next cycle.
- R4: The word at offset k of buffer b is written to ringBase[b] + 4*k with the accepted data. Offsets start at 0 in each buffer and count up to bufWords-1.
- R5: Buffers fill in the order 0, 1, 2, 3, and the ring returns to buffer 0 after buffer 3 while tracing stays enabled.
- R6: The cycle after the acknowledge of a buffer's last word, doneStrobe is high for exactly one cycle, and doneIndex carries that buffer's index (0 to 3).
- R7: Bit b of doneSticky is set when buffer b completes and is cleared by a cycle with stickyClear[b] high. When a set and a clear reach the same bit in the same cycle, the set takes effect.
- R8: When traceEnable falls, any pending write still completes. Then stopStrobe is high for one cycle, with stopIndex set to the current buffer and stopLevel set to the number of words already written into it, and no further request is issued.
- R9: A new rising traceEnable after a stop restarts writing at buffer 0, offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| traceEnable | input | 1 | Tracing on/off |
| ringBase | input | 4 x ADDR_W | Byte base address of each buffer, entry b for buffer b |
| bufWords | input | SIZE_W | Buffer size in words (nonzero) |
| inValid | input | 1 | Trace word offered |
| inData | input | DATA_W | Trace word |
| inReady | output | 1 | Trace word accepted when high with inValid |
| memReq | output | 1 | Memory write request |
| memAddr | output | ADDR_W | Write byte address |
| memData | output | DATA_W | Write data |
| memAck | input | 1 | Write acknowledge |
| doneStrobe | output | 1 | Buffer-complete pulse |
| doneIndex | output | 2 | Index of the completed buffer |
| doneSticky | output | 4 | Per-buffer completion flags |
| stickyClear | input | 4 | Clear mask for doneSticky |
| stopStrobe | output | 1 | Stop-report pulse |
| stopIndex | output | 2 | Buffer in use at stop |
| stopLevel | output | SIZE_W | Words held in that buffer at stop |

## Verification
Several properties are checked on every cycle: input acceptance never overlaps a pending write, a request holds its address and data until it is acknowledged, a completion pulse lasts one cycle and always follows an acknowledge with the matching sticky bit set, and a stop report never appears while a request is active. Other behaviour can only be shown by the bench's scenarios. These are the exact address sequence through all four buffers and the wrap back to the first, the partial fill level reported at a stop, the priority of a set over a clear on a sticky bit, and the restart at buffer 0 after a new enable.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;
  localparam int NUM_BUF = 4;
  localparam int IDX_W = $clog2(NUM_BUF);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WRITE} ringState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearPtr;  // return to buffer 0, offset 0
    logic load;      // capture input word and its address
    logic advance;   // write acknowledged, step the pointer
  } ringCtl_t;
endpackage

// File: rtl/trace_ring_dp.sv
module trace_ring_dp
  import trace_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 21
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ringCtl_t                         ctl,
  input  logic [NUM_BUF-1:0][ADDR_W-1:0]   ringBase,
  input  logic [SIZE_W-1:0]                bufWords,
  input  logic [DATA_W-1:0]                inData,
  output logic [ADDR_W-1:0]                memAddr,
  output logic [DATA_W-1:0]                memData,
  output logic [IDX_W-1:0]                 curIdx,
  output logic [SIZE_W-1:0]                curOff,
  output logic                             lastWord
);
  localparam int BYTE_OFF_W = SIZE_W + 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUF - 1);

  logic [BYTE_OFF_W-1:0] byteOff;
  logic [IDX_W-1:0]      nextIdx;

  assign byteOff  = {curOff, 2'b00};
  assign lastWord = (curOff == bufWords - SIZE_W'(1));
  assign nextIdx  = (curIdx == LAST_IDX) ? '0 : curIdx + IDX_W'(1);

  // ring pointer: buffer index and word offset
  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearPtr) begin
      curIdx <= '0;
      curOff <= '0;
    end else if (ctl.advance) begin
      if (lastWord) begin
        curOff <= '0;
        curIdx <= nextIdx;
      end else begin
        curOff <= curOff + SIZE_W'(1);
      end
    end
  end

  // request holding registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
      memData <= '0;
    end else if (ctl.load) begin
      memAddr <= ringBase[curIdx] + ADDR_W'(byteOff);
      memData <= inData;
    end
  end
endmodule

// File: rtl/trace_ring_ctl.sv
module trace_ring_ctl
  import trace_ring_pkg::*;
#(
  parameter int SIZE_W = 21
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                traceEnable,
  input  logic                inValid,
  input  logic                memAck,
  input  logic [IDX_W-1:0]    curIdx,
  input  logic [SIZE_W-1:0]   curOff,
  input  logic                lastWord,
  input  logic [NUM_BUF-1:0]  stickyClear,
  output ringCtl_t            ctl,
  output logic                inReady,
  output logic                memReq,
  output logic                doneStrobe,
  output logic [IDX_W-1:0]    doneIndex,
  output logic [NUM_BUF-1:0]  doneSticky,
  output logic                stopStrobe,
  output logic [IDX_W-1:0]    stopIndex,
  output logic [SIZE_W-1:0]   stopLevel
);
  ringState_e          state;
  logic                bufFull;
  logic                haltNow;
  logic [NUM_BUF-1:0]  setMask;

  always_comb begin
    inReady      = (state == ST_RUN) && traceEnable;
    memReq       = (state == ST_WRITE);
    ctl          = '0;
    ctl.clearPtr = (state == ST_IDLE);
    ctl.load     = inReady && inValid;
    ctl.advance  = memReq && memAck;
    bufFull      = ctl.advance && lastWord;
    haltNow      = (state == ST_RUN) && !traceEnable;
    setMask      = bufFull ? (NUM_BUF'(1) << curIdx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (traceEnable) state <= ST_RUN;
        ST_RUN: begin
          if (!traceEnable)  state <= ST_IDLE;
          else if (inValid)  state <= ST_WRITE;
        end
        ST_WRITE: if (memAck) state <= ST_RUN;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // completion and stop reporting
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneStrobe <= 1'b0;
      doneIndex  <= '0;
      doneSticky <= '0;
      stopStrobe <= 1'b0;
      stopIndex  <= '0;
      stopLevel  <= '0;
    end else begin
      doneStrobe <= bufFull;
      if (bufFull) doneIndex <= curIdx;
      doneSticky <= (doneSticky & ~stickyClear) | setMask;
      stopStrobe <= haltNow;
      if (haltNow) begin
        stopIndex <= curIdx;
        stopLevel <= curOff;
      end
    end
  end
endmodule

// File: rtl/trace_ring_writer.sv
module trace_ring_writer
  import trace_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 21
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            traceEnable,
  input  logic [NUM_BUF-1:0][ADDR_W-1:0]  ringBase,
  input  logic [SIZE_W-1:0]               bufWords,
  input  logic                            inValid,
  input  logic [DATA_W-1:0]               inData,
  output logic                            inReady,
  output logic                            memReq,
  output logic [ADDR_W-1:0]               memAddr,
  output logic [DATA_W-1:0]               memData,
  input  logic                            memAck,
  output logic                            doneStrobe,
  output logic [IDX_W-1:0]                doneIndex,
  output logic [NUM_BUF-1:0]              doneSticky,
  input  logic [NUM_BUF-1:0]              stickyClear,
  output logic                            stopStrobe,
  output logic [IDX_W-1:0]                stopIndex,
  output logic [SIZE_W-1:0]               stopLevel
);
  ringCtl_t            ctl;
  logic [IDX_W-1:0]    curIdx;
  logic [SIZE_W-1:0]   curOff;
  logic                lastWord;

  trace_ring_ctl #(.SIZE_W(SIZE_W)) uCtl (
    .clk(clk), .rstN(rstN), .traceEnable(traceEnable), .inValid(inValid),
    .memAck(memAck), .curIdx(curIdx), .curOff(curOff), .lastWord(lastWord),
    .stickyClear(stickyClear), .ctl(ctl), .inReady(inReady), .memReq(memReq),
    .doneStrobe(doneStrobe), .doneIndex(doneIndex), .doneSticky(doneSticky),
    .stopStrobe(stopStrobe), .stopIndex(stopIndex), .stopLevel(stopLevel)
  );

  trace_ring_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ringBase(ringBase), .bufWords(bufWords),
    .inData(inData), .memAddr(memAddr), .memData(memData), .curIdx(curIdx),
    .curOff(curOff), .lastWord(lastWord)
  );
endmodule

// File: rtl/trace_ring_writer_chk.sv
module trace_ring_writer_chk
  import trace_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                inReady,
  input logic                memReq,
  input logic                memAck,
  input logic [ADDR_W-1:0]   memAddr,
  input logic [DATA_W-1:0]   memData,
  input logic                doneStrobe,
  input logic [IDX_W-1:0]    doneIndex,
  input logic [NUM_BUF-1:0]  doneSticky,
  input logic                stopStrobe
);
  assert_no_accept_during_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && inReady));

  assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memData)));

  assert_drop_after_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> !memReq);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe);

  assert_done_follows_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> $past(memReq && memAck));

  assert_sticky_on_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> doneSticky[doneIndex]);

  assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    stopStrobe |-> (!memReq && !inReady));
endmodule

bind trace_ring_writer trace_ring_writer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .memReq(memReq), .memAck(memAck),
  .memAddr(memAddr), .memData(memData), .doneStrobe(doneStrobe),
  .doneIndex(doneIndex), .doneSticky(doneSticky), .stopStrobe(stopStrobe)
);

// File: tb/trace_ring_writer_test.sv
module trace_ring_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int SIZE_W = 21;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [31:0] data;
    logic [31:0] addr;
    logic        done;
    logic [1:0]  idx;
  } vec_t;

  // bufWords = 3; bases 0x10000000, 0x20000100, 0x30000200, 0x00004000
  localparam vec_t VECS [NVEC] = '{
    '{32'hC0DE0000, 32'h10000000, 1'b0, 2'd0},
    '{32'hC0DE0001, 32'h10000004, 1'b0, 2'd0},
    '{32'hC0DE0002, 32'h10000008, 1'b1, 2'd0},
    '{32'hC0DE0003, 32'h20000100, 1'b0, 2'd1},
    '{32'hC0DE0004, 32'h20000104, 1'b0, 2'd1},
    '{32'hC0DE0005, 32'h20000108, 1'b1, 2'd1},
    '{32'hC0DE0006, 32'h30000200, 1'b0, 2'd2},
    '{32'hC0DE0007, 32'h30000204, 1'b0, 2'd2},
    '{32'hC0DE0008, 32'h30000208, 1'b1, 2'd2},
    '{32'hC0DE0009, 32'h00004000, 1'b0, 2'd3},
    '{32'hC0DE000A, 32'h00004004, 1'b0, 2'd3},
    '{32'hC0DE000B, 32'h00004008, 1'b1, 2'd3},
    '{32'hC0DE000C, 32'h10000000, 1'b0, 2'd0},
    '{32'hC0DE000D, 32'h10000004, 1'b0, 2'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic traceEnable = 1'b0;
  logic [3:0][ADDR_W-1:0] ringBase;
  logic [SIZE_W-1:0] bufWords = SIZE_W'(3);
  logic inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic inReady, memReq, memAck = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memData;
  logic doneStrobe, stopStrobe;
  logic [1:0] doneIndex, stopIndex;
  logic [3:0] doneSticky;
  logic [3:0] stickyClear = '0;
  logic [SIZE_W-1:0] stopLevel;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  assign ringBase = {32'h00004000, 32'h30000200, 32'h20000100, 32'h10000000};

  trace_ring_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) uut (
    .clk(clk), .rstN(rstN), .traceEnable(traceEnable), .ringBase(ringBase),
    .bufWords(bufWords), .inValid(inValid), .inData(inData), .inReady(inReady),
    .memReq(memReq), .memAddr(memAddr), .memData(memData), .memAck(memAck),
    .doneStrobe(doneStrobe), .doneIndex(doneIndex), .doneSticky(doneSticky),
    .stickyClear(stickyClear), .stopStrobe(stopStrobe), .stopIndex(stopIndex),
    .stopLevel(stopLevel)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // offer one word; returns at the negedge where its request is visible
  task automatic pushWord(input logic [31:0] d);
    @(negedge clk);
    inValid = 1'b1;
    inData = d;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // hold the acknowledge back for waitCyc cycles, then give it
  task automatic ackWrite(input int waitCyc);
    logic [31:0] held;
    held = memAddr;
    for (int k = 0; k < waitCyc; k++) begin
      @(negedge clk);
      check(memReq && memAddr == held, "R3 hold", {31'd0, memReq, memAddr}, {32'd1, held});
      check(!inReady, "R2 no accept while pending", 64'(inReady), 64'd0);
    end
    memAck = 1'b1;
    @(negedge clk);
    memAck = 1'b0;
    check(!memReq, "R3 drop after ack", 64'(memReq), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!memReq && !inReady && !doneStrobe && !stopStrobe && doneSticky == 4'h0,
          "R1 reset", {memReq, inReady, doneStrobe, stopStrobe, doneSticky}, 64'd0);

    // R2: offered words while disabled are ignored
    inValid = 1'b1;
    repeat (3) @(negedge clk);
    check(!memReq && !inReady, "R2 disabled ignore", {memReq, inReady}, 64'd0);
    inValid = 1'b0;

    traceEnable = 1'b1;
    // table walk: R4 addresses, R5 order and wrap, R6 done pulse
    for (int i = 0; i < NVEC; i++) begin
      pushWord(VECS[i].data);
      check(memReq, "R3 request", 64'(memReq), 64'd1);
      check(memAddr == VECS[i].addr, "R4 address", 64'(memAddr), 64'(VECS[i].addr));
      check(memData == VECS[i].data, "R4 data", 64'(memData), 64'(VECS[i].data));
      ackWrite(i % 3);
      check(doneStrobe == VECS[i].done, "R6 done pulse", 64'(doneStrobe), 64'(VECS[i].done));
      if (VECS[i].done)
        check(doneIndex == VECS[i].idx, "R5 done index", 64'(doneIndex), 64'(VECS[i].idx));
      @(negedge clk);
      check(!doneStrobe, "R6 single cycle", 64'(doneStrobe), 64'd0);
    end

    // R7 sticky flags and clearing
    check(doneSticky == 4'hF, "R7 all set", 64'(doneSticky), 64'hF);
    stickyClear = 4'b0101;
    @(negedge clk);
    stickyClear = 4'b0000;
    check(doneSticky == 4'b1010, "R7 clear", 64'(doneSticky), 64'hA);

    // R7 set wins over clear on the same bit
    pushWord(32'hBEEF0001);
    check(memAddr == 32'h10000008, "R4 last word buf0", 64'(memAddr), 64'h10000008);
    memAck = 1'b1;
    stickyClear = 4'b0001;
    @(negedge clk);
    memAck = 1'b0;
    stickyClear = 4'b0000;
    check(doneStrobe && doneIndex == 2'd0, "R6 wrap done", {doneStrobe, doneIndex}, {1'b1, 2'd0});
    check(doneSticky == 4'b1011, "R7 set wins", 64'(doneSticky), 64'hB);

    // R8 stop with partial fill in buffer 1
    pushWord(32'hBEEF0002);
    check(memAddr == 32'h20000100, "R5 second lap buf1", 64'(memAddr), 64'h20000100);
    ackWrite(0);
    traceEnable = 1'b0;
    @(negedge clk);
    check(stopStrobe && stopIndex == 2'd1 && stopLevel == SIZE_W'(1), "R8 stop report",
          {stopStrobe, stopIndex, 32'(stopLevel)}, {1'b1, 2'd1, 32'd1});
    check(!inReady, "R8 no accept after stop", 64'(inReady), 64'd0);
    @(negedge clk);
    check(!stopStrobe, "R8 stop single", 64'(stopStrobe), 64'd0);
    check(doneSticky == 4'b1011, "R7 unchanged by stop", 64'(doneSticky), 64'hB);

    // R9 restart at buffer 0, then R8 disable during a pending write
    traceEnable = 1'b1;
    pushWord(32'hBEEF0003);
    check(memAddr == 32'h10000000, "R9 restart address", 64'(memAddr), 64'h10000000);
    traceEnable = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check(memReq, "R8 pending write kept", 64'(memReq), 64'd1);
    end
    memAck = 1'b1;
    @(negedge clk);
    memAck = 1'b0;
    @(negedge clk);
    check(stopStrobe && stopIndex == 2'd0 && stopLevel == SIZE_W'(1) && !memReq,
          "R8 stop after pending", {memReq, stopStrobe, stopIndex, 32'(stopLevel)},
          {1'b0, 1'b1, 2'd0, 32'd1});
    repeat (3) @(negedge clk);
    check(!memReq, "R8 no further request", 64'(memReq), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule